// File: doc/BRIEF.md
# Parallel Printer Port Register Interface

This block is a byte-wide printer port controller sitting behind a small host register bus. Software sees three registers: an output data byte, a printer status byte and a control byte. Writing the control byte drives a strobe handshake with an emulated printer. A rising strobe, seen while the printer is initialised and selected, pushes the latched output byte out on a byte-stream port as a single-cycle pulse. Reading the status byte steps the printer's acknowledge and busy flags through their handshake sequence. This lets a polling driver watch a character being accepted.

A level interrupt is raised when a strobe is released with the interrupt enable set. A status read clears it. A separate input latch holds a byte for reverse-direction reads. The bus address is shifted right by a parameter before the low three bits pick the register, so the register file can sit on a wider memory bus at any stride.

Top module: `ppt_regif`

## Requirements
- R1: After reset the output and input data bytes are 0xFF, status reads 0xD9, control reads 0xCC, irq is 0 and byte_valid is 0.
- R2: The register offset is bits [2:0] of bus_addr shifted right by ADDR_SHIFT. The offsets are 0 data, 1 status and 2 control. A read of offsets 3 to 7 returns 0xFF. Writes to offsets 1 and 3 to 7 change nothing.
- R3: Read data is registered. It appears on bus_rdata, zero-extended, after the clock edge that takes the read, and it holds until the next read. A control write stores bits 5:0, and bits 7:6 always read as 1.
- R4: A control write with bit 2 (init) at 0 loads status with 0xD8.
- R5: A control write with init (bit 2) and select (bit 3) at 1 and strobe (bit 0) at 1 clears status bit 7. If the previous control value had strobe at 0, it also emits the last written data byte on byte_out, with byte_valid high for exactly one cycle after that write's edge.
- R6: A control write with init and select at 1 and strobe at 0 sets irq after its edge when the previous control value had bit 4 (interrupt enable) at 1.
- R7: A status read returns the current status, and irq is 0 after its edge.
- R8: A status read taken while status bit 7 is 0 and control strobe is 0 then steps status. If bit 6 (acknowledge) is 1 it is cleared. Otherwise bits 7 and 6 are both set.
- R9: A data read returns the input latch (loaded by rev_load with rev_byte) when control bit 5 is 1, and the last written data byte when it is 0.
- R10: When bus_wr and bus_rd are high in the same cycle, only the write takes effect and bus_rdata keeps its old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Byte address from the host bus |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_rd | input | 1 | Read strobe, one access per cycle |
| bus_wdata | input | 8 | Write data byte |
| bus_rdata | output | DATA_W | Registered read data, zero-extended |
| rev_load | input | 1 | Load the input latch |
| rev_byte | input | 8 | Byte captured by rev_load |
| irq | output | 1 | Level interrupt |
| byte_out | output | 8 | Byte emitted to the printer |
| byte_valid | output | 1 | One-cycle pulse qualifying byte_out |

## Verification
The hardest state to reach is the acknowledge and busy walk. It needs status bit 7 cleared by a strobed control write, then strobe released, and only then a chain of status reads. Interrupts depend on the enable bit of the previous control value, not the new one. To cover both, the bench sweeps every ordered pair of control bytes in its six low bits. Each pair is followed by two status reads, a control read and a data read, so that every handshake path and every interrupt arming order appears from clean and dirty status states alike.

// File: rtl/ppt_pkg.sv
package ppt_pkg;
   localparam logic [2:0] OFS_DATA = 3'd0;
   localparam logic [2:0] OFS_STAT = 3'd1;
   localparam logic [2:0] OFS_CTRL = 3'd2;

   localparam int ST_NBUSY = 7;
   localparam int ST_ACK   = 6;

   localparam int CT_DIR  = 5;
   localparam int CT_IEN  = 4;
   localparam int CT_SEL  = 3;
   localparam int CT_INIT = 2;
   localparam int CT_STB  = 0;

   localparam logic [7:0] STAT_RST    = 8'hD9;
   localparam logic [7:0] STAT_INIT   = 8'hD8;
   localparam logic [7:0] CTRL_RST    = 8'hCC;
   localparam logic [7:0] CTRL_FORCED = 8'hC0;
   localparam logic [7:0] BYTE_ONES   = 8'hFF;
endpackage

// File: rtl/ppt_addr_dec.sv
module ppt_addr_dec #(
   parameter int ADDR_W     = 8,
   parameter int ADDR_SHIFT = 0
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              rd,
   input  logic              wr,
   output logic              wr_data,
   output logic              wr_ctrl,
   output logic              rd_data,
   output logic              rd_stat,
   output logic              rd_ctrl,
   output logic              rd_other
);
   import ppt_pkg::*;

   localparam int TOP = ADDR_SHIFT + 3;

   logic [2:0] ofs;
   logic       rd_eff;

   generate
      if (ADDR_SHIFT == 0) begin : g_noshift
         assign ofs = addr[2:0];
      end else begin : g_shift
         logic unused_lo;
         assign unused_lo = ^addr[ADDR_SHIFT-1:0];
         assign ofs       = addr[ADDR_SHIFT +: 3];
      end
      if (ADDR_W > TOP) begin : g_hi
         logic unused_hi;
         assign unused_hi = ^addr[ADDR_W-1:TOP];
      end
   endgenerate

   // a write in the same cycle wins over a read
   assign rd_eff   = rd & ~wr;
   assign wr_data  = wr & (ofs == OFS_DATA);
   assign wr_ctrl  = wr & (ofs == OFS_CTRL);
   assign rd_data  = rd_eff & (ofs == OFS_DATA);
   assign rd_stat  = rd_eff & (ofs == OFS_STAT);
   assign rd_ctrl  = rd_eff & (ofs == OFS_CTRL);
   assign rd_other = rd_eff & (ofs > OFS_CTRL);
endmodule

// File: rtl/ppt_ctrl_seq.sv
module ppt_ctrl_seq (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_ctrl,
   input  logic       rd_stat,
   input  logic [7:0] wval,
   output logic [7:0] ctrl_q,
   output logic [7:0] status_q,
   output logic       pend_q,
   output logic       emit_q
);
   import ppt_pkg::*;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q   <= CTRL_RST;
         status_q <= STAT_RST;
         pend_q   <= 1'b0;
         emit_q   <= 1'b0;
      end else begin
         emit_q <= 1'b0;
         if (wr_ctrl) begin
            ctrl_q <= wval | CTRL_FORCED;
            if (!wval[CT_INIT]) begin
               status_q <= STAT_INIT;
            end else if (wval[CT_SEL]) begin
               if (wval[CT_STB]) begin
                  status_q[ST_NBUSY] <= 1'b0;
                  emit_q             <= ~ctrl_q[CT_STB];
               end else if (ctrl_q[CT_IEN]) begin
                  pend_q <= 1'b1;
               end
            end
         end else if (rd_stat) begin
            pend_q <= 1'b0;
            if (!status_q[ST_NBUSY] && !ctrl_q[CT_STB]) begin
               if (status_q[ST_ACK]) begin
                  status_q[ST_ACK] <= 1'b0;
               end else begin
                  status_q[ST_ACK]   <= 1'b1;
                  status_q[ST_NBUSY] <= 1'b1;
               end
            end
         end
      end
   end
endmodule

// File: rtl/ppt_data_path.sv
module ppt_data_path (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_data,
   input  logic [7:0] wval,
   input  logic       rev_load,
   input  logic [7:0] rev_byte,
   output logic [7:0] dataw_q,
   output logic [7:0] datar_q
);
   import ppt_pkg::*;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dataw_q <= BYTE_ONES;
         datar_q <= BYTE_ONES;
      end else begin
         if (wr_data)  dataw_q <= wval;
         if (rev_load) datar_q <= rev_byte;
      end
   end
endmodule

// File: rtl/ppt_regif.sv
module ppt_regif #(
   parameter int ADDR_W     = 8,
   parameter int ADDR_SHIFT = 0,
   parameter int DATA_W     = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [7:0]        bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              rev_load,
   input  logic [7:0]        rev_byte,
   output logic              irq,
   output logic [7:0]        byte_out,
   output logic              byte_valid
);
   import ppt_pkg::*;

   generate
      if (DATA_W < 8) begin : g_bad_dw
         $error("DATA_W must be at least 8");
      end
      if (ADDR_W < ADDR_SHIFT + 3) begin : g_bad_aw
         $error("ADDR_W must cover ADDR_SHIFT plus three offset bits");
      end
   endgenerate

   logic       wr_data, wr_ctrl, rd_data, rd_stat, rd_ctrl, rd_other;
   logic [7:0] ctrl_q, status_q, dataw_q, datar_q, rdata_q;
   logic       pend_q, emit_q;

   ppt_addr_dec #(.ADDR_W(ADDR_W), .ADDR_SHIFT(ADDR_SHIFT)) u_dec (
      .addr    (bus_addr),
      .rd      (bus_rd),
      .wr      (bus_wr),
      .wr_data (wr_data),
      .wr_ctrl (wr_ctrl),
      .rd_data (rd_data),
      .rd_stat (rd_stat),
      .rd_ctrl (rd_ctrl),
      .rd_other(rd_other)
   );

   ppt_ctrl_seq u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_ctrl (wr_ctrl),
      .rd_stat (rd_stat),
      .wval    (bus_wdata),
      .ctrl_q  (ctrl_q),
      .status_q(status_q),
      .pend_q  (pend_q),
      .emit_q  (emit_q)
   );

   ppt_data_path u_dp (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_data (wr_data),
      .wval    (bus_wdata),
      .rev_load(rev_load),
      .rev_byte(rev_byte),
      .dataw_q (dataw_q),
      .datar_q (datar_q)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rdata_q <= 8'h00;
      end else if (rd_data) begin
         rdata_q <= ctrl_q[CT_DIR] ? datar_q : dataw_q;
      end else if (rd_stat) begin
         rdata_q <= status_q;
      end else if (rd_ctrl) begin
         rdata_q <= ctrl_q;
      end else if (rd_other) begin
         rdata_q <= BYTE_ONES;
      end
   end

   generate
      if (DATA_W > 8) begin : g_wide
         assign bus_rdata = {{(DATA_W-8){1'b0}}, rdata_q};
      end else begin : g_narrow
         assign bus_rdata = rdata_q[DATA_W-1:0];
      end
   endgenerate

   assign irq        = pend_q;
   assign byte_valid = emit_q;
   assign byte_out   = dataw_q;
endmodule

// File: rtl/ppt_regif_chk.sv
module ppt_regif_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       wr_ctrl,
   input logic       rd_stat,
   input logic       rd_other,
   input logic [7:0] wval,
   input logic [7:0] ctrl_q,
   input logic [7:0] status_q,
   input logic [7:0] rdata8,
   input logic       irq,
   input logic       byte_valid
);
   // R3: control write stores the byte with the top bits forced
   a_r3_ctrl_store: assert property (@(posedge clk) disable iff (!rst_n)
      wr_ctrl |=> ctrl_q == ($past(wval) | 8'hC0));

   // R4: init low loads the fixed status
   a_r4_init_load: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ctrl && !wval[2]) |=> status_q == 8'hD8);

   // R5: strobed write while selected clears busy bit
   a_r5_busy_clr: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ctrl && wval[2] && wval[3] && wval[0]) |=> !status_q[7]);

   // R5: emission only on a strobe rise from a control write
   a_r5_emit_edge: assert property (@(posedge clk) disable iff (!rst_n)
      byte_valid |-> (ctrl_q[0] && !$past(ctrl_q[0]) && $past(wr_ctrl)));

   // R5: one-cycle pulse
   a_r5_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      byte_valid |=> !byte_valid);

   // R7: status read drops the interrupt
   a_r7_irq_drop: assert property (@(posedge clk) disable iff (!rst_n)
      rd_stat |=> !irq);

   // R8: acknowledge falls first in the handshake walk
   a_r8_ack_fall: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stat && !status_q[7] && !ctrl_q[0] && status_q[6])
         |=> (!status_q[6] && !status_q[7]));

   // R2: unused offsets read all ones
   a_r2_other_ff: assert property (@(posedge clk) disable iff (!rst_n)
      rd_other |=> rdata8 == 8'hFF);
endmodule

bind ppt_regif ppt_regif_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .wr_ctrl   (wr_ctrl),
   .rd_stat   (rd_stat),
   .rd_other  (rd_other),
   .wval      (bus_wdata),
   .ctrl_q    (ctrl_q),
   .status_q  (status_q),
   .rdata8    (rdata_q),
   .irq       (irq),
   .byte_valid(byte_valid)
);

// File: tb/tb_ppt_regif.sv
`timescale 1ns/1ps
module tb_ppt_regif;
   localparam int AW = 8;
   localparam int SH = 2;
   localparam int DW = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic          bus_wr = 1'b0, bus_rd = 1'b0;
   logic [7:0]    bus_wdata = '0;
   logic [DW-1:0] bus_rdata;
   logic          rev_load = 1'b0;
   logic [7:0]    rev_byte = '0;
   logic          irq, byte_valid;
   logic [7:0]    byte_out;

   int checks = 0;
   int fails  = 0;

   logic [7:0] m_st = 8'hD9, m_ct = 8'hCC, m_dw = 8'hFF, m_dr = 8'hFF;
   logic       m_pend = 1'b0;

   always #2.5 clk = ~clk;

   ppt_regif #(.ADDR_W(AW), .ADDR_SHIFT(SH), .DATA_W(DW)) dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .rev_load(rev_load), .rev_byte(rev_byte), .irq(irq),
      .byte_out(byte_out), .byte_valid(byte_valid)
   );

   task automatic chk(input bit ok, input string tag,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // expected-state update for a write, from the requirements
   task automatic model_wr(input int ofs, input logic [7:0] v, output bit emit);
      logic [7:0] nv;
      emit = 1'b0;
      if (ofs == 0) m_dw = v;
      else if (ofs == 2) begin
         nv = v | 8'hC0;
         if (!nv[2]) m_st = 8'hD8;
         else if (nv[3]) begin
            if (nv[0]) begin
               m_st[7] = 1'b0;
               if (!m_ct[0]) emit = 1'b1;
            end else if (m_ct[4]) m_pend = 1'b1;
         end
         m_ct = nv;
      end
   endtask

   task automatic do_wr(input int ofs, input logic [7:0] v);
      bit e;
      @(negedge clk);
      bus_addr  = AW'((ofs << SH) | 3);
      bus_wdata = v;
      bus_wr    = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
      model_wr(ofs, v, e);
      chk(byte_valid == e, "R5 byte_valid", 32'(byte_valid), 32'(e));
      if (e) chk(byte_out == m_dw, "R5 byte_out", 32'(byte_out), 32'(m_dw));
      chk(irq == m_pend, "R6 irq after write", 32'(irq), 32'(m_pend));
   endtask

   task automatic do_rd(input int ofs, output logic [7:0] got);
      logic [7:0] exp;
      string      tag;
      @(negedge clk);
      bus_addr = AW'((ofs << SH) | 1);
      bus_rd   = 1'b1;
      @(negedge clk);
      bus_rd = 1'b0;
      got = bus_rdata[7:0];
      case (ofs)
         0: begin exp = m_ct[5] ? m_dr : m_dw; tag = "R9 data read"; end
         1: begin
            exp = m_st; tag = "R8 status read";
            m_pend = 1'b0;
            if (!m_st[7] && !m_ct[0]) begin
               if (m_st[6]) m_st[6] = 1'b0;
               else m_st[7:6] = 2'b11;
            end
         end
         2: begin exp = m_ct; tag = "R3 control read"; end
         default: begin exp = 8'hFF; tag = "R2 other offset"; end
      endcase
      chk(bus_rdata == {24'h0, exp}, tag, bus_rdata, {24'h0, exp});
      chk(irq == m_pend, "R7 irq after read", 32'(irq), 32'(m_pend));
   endtask

   task automatic do_rev(input logic [7:0] b);
      @(negedge clk);
      rev_load = 1'b1;
      rev_byte = b;
      @(negedge clk);
      rev_load = 1'b0;
      m_dr = b;
   endtask

   task automatic summary;
      $display("%0d/%0d checks passed", checks - fails, checks);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
   end

   initial begin
      logic [7:0] g, prev;
      bit         e;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(irq == 1'b0, "R1 irq", 32'(irq), 0);
      chk(byte_valid == 1'b0, "R1 byte_valid", 32'(byte_valid), 0);
      do_rd(1, g); chk(g == 8'hD9, "R1 status", 32'(g), 32'hD9);
      do_rd(2, g); chk(g == 8'hCC, "R1 control", 32'(g), 32'hCC);
      do_rd(0, g); chk(g == 8'hFF, "R1 output data", 32'(g), 32'hFF);
      do_wr(2, 8'h2C);
      do_rd(0, g); chk(g == 8'hFF, "R1 input latch", 32'(g), 32'hFF);

      // R9 reverse latch vs output byte
      do_rev(8'h3A);
      do_wr(0, 8'hC5);
      do_rd(0, g); chk(g == 8'h3A, "R9 dir=1", 32'(g), 32'h3A);
      do_wr(2, 8'h0C);
      do_rd(0, g); chk(g == 8'hC5, "R9 dir=0", 32'(g), 32'hC5);

      // R4 init low
      do_wr(2, 8'h08);
      do_rd(1, g); chk(g == 8'hD8, "R4 init load", 32'(g), 32'hD8);

      // R5 / R8 handshake walk
      do_wr(2, 8'h0C);
      do_wr(0, 8'h41);
      do_wr(2, 8'h0D);
      do_wr(2, 8'h0C);
      do_rd(1, g); chk(g == 8'h58, "R8 busy", 32'(g), 32'h58);
      do_rd(1, g); chk(g == 8'h18, "R8 ack cleared", 32'(g), 32'h18);
      do_rd(1, g); chk(g == 8'hD8, "R8 ack and busy set", 32'(g), 32'hD8);

      // R6 interrupt arming and R7 clear
      do_wr(2, 8'h1C);
      do_wr(2, 8'h1C);
      chk(irq == 1'b1, "R6 irq set", 32'(irq), 1);
      do_rd(1, g);
      chk(irq == 1'b0, "R7 irq cleared", 32'(irq), 0);

      // R2 ignored writes and all-ones offsets
      prev = m_st;
      do_wr(1, 8'h00);
      do_wr(5, 8'h00);
      do_wr(7, 8'h00);
      do_rd(1, g); chk(g == prev, "R2 status write ignored", 32'(g), 32'(prev));
      do_rd(2, g); chk(g == m_ct, "R2 control untouched", 32'(g), 32'(m_ct));
      for (int k = 3; k < 8; k++) do_rd(k, g);

      // R10 simultaneous read and write
      do_rd(0, g);
      prev = g;
      @(negedge clk);
      bus_addr  = AW'(2 << SH);
      bus_wdata = 8'h04;
      bus_wr    = 1'b1;
      bus_rd    = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
      bus_rd = 1'b0;
      model_wr(2, 8'h04, e);
      chk(bus_rdata[7:0] == prev, "R10 read suppressed", bus_rdata, 32'(prev));
      do_rd(2, g); chk(g == 8'hC4, "R10 write taken", 32'(g), 32'hC4);

      // sweep every ordered pair of control values
      for (int a = 0; a < 64; a++) begin
         for (int b = 0; b < 64; b++) begin
            if (a == b) do_rev(8'(a ^ 8'hF0));
            do_wr(0, 8'((a << 2) ^ b ^ 8'h5A));
            do_wr(2, 8'(a));
            do_wr(2, 8'(b));
            do_rd(1, g);
            do_rd(1, g);
            do_rd(2, g);
            do_rd(0, g);
         end
      end

      summary();
      $finish;
   end
endmodule